// File: doc/BRIEF.md
# I/O Chip-Select Decoder for Configurable Peripheral Functions

This block sits between the configuration register file of a multi-function peripheral controller and its host I/O bus. For each logical peripheral function (floppy controller, parallel port, two serial ports, an auxiliary single-port register and a two-wire bus controller) it forms a 16-bit I/O base from a high and a low base byte. It enables that function only when both its activation byte and, where one applies, its bit in a global enable byte are set. The base must also lie in the window the function allows. When all of this holds, the block drives that function's chip select while the host address falls inside the function's port span.

A separate two-port general-purpose I/O window is decoded from a control byte. Its top bit enables the window, and its two low bits pick one of four fixed base addresses. The block also passes each function's interrupt number through, and limits the parallel port's interrupt number to the legal range.

Everything is combinational: selects follow the host address and register values with no clock. If programmed windows overlap, a fixed priority keeps the select vector one-hot or all zero. There is no data path through this block, so it has no valid/ready handshake. All of its pins are plain level signals.

Top module: `sio_addr_decoder`

## Requirements
- R1: A function's base is `base_hi[i]` times 256 plus `base_lo[i]`. The function is hit when `host_addr` is at least the base and less than base plus its span.
- R2: Spans, by index: 0 floppy 8 ports, 1 parallel 4, 2 serial-A 8, 3 serial-B 8, 4 auxiliary register 1, 5 two-wire bus 4.
- R3: A function decodes only when its base lies in its legal range. Floppy and both serial ports accept 0x0100..0x0FF8, parallel and two-wire bus accept 0x0100..0x0FFC, and the auxiliary register accepts 0x0100..0x0FFF. Outside that range the function never selects.
- R4: `glob_en_reg` gates the functions by bit: bit 0 floppy, bit 3 parallel, bit 4 serial-A, bit 5 serial-B, bit 6 two-wire bus. The auxiliary register ignores `glob_en_reg`, and bits 1, 2 and 7 have no effect.
- R5: A function is active only while its `activate[i]` byte is nonzero, whatever its value.
- R6: The GPIO window is enabled by `gpio_ctl_reg` bit 7 and spans 2 ports. Its base is 0xE0, 0xE2, 0xE4 or 0xEA for `gpio_ctl_reg[1:0]` = 0, 1, 2, 3.
- R7: `dev_irq[1]` (parallel) is 0xFF when `irq_reg[1]` exceeds 15, and equals it otherwise. Every other `dev_irq[i]` equals `irq_reg[i]`.
- R8: `dev_sel` bits 0..5 are the functions in index order and bit 6 is GPIO. At most one bit is set, and the lowest-numbered hit wins.
- R9: Selects depend only on the present input values, with no cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_addr | input | 16 | Host I/O address being decoded |
| glob_en_reg | input | 8 | Global function-enable byte |
| gpio_ctl_reg | input | 8 | GPIO window control: bit 7 enable, bits 1:0 base choice |
| activate | input | 6x8 | Per-function activation byte |
| base_hi | input | 6x8 | Per-function base address, high byte |
| base_lo | input | 6x8 | Per-function base address, low byte |
| irq_reg | input | 6x8 | Per-function programmed interrupt number |
| dev_sel | output | 7 | One-hot chip selects, functions 0..5 then GPIO |
| dev_irq | output | 6x8 | Per-function interrupt number after range limiting |

## Verification
The bench builds the block with its default 8-bit register width, which gives a 16-bit address. At that size the whole legal base range up to 0x0FFF, and the addresses just past it, can be swept one host address at a time against an arithmetic model. It also reaches every window boundary, every GPIO base choice, stacked overlaps that exercise the priority chain, and all 256 interrupt values for every function.

// File: rtl/sio_dec_pkg.sv
package sio_dec_pkg;
  localparam int NUM_DEV     = 6;
  localparam int NUM_SEL     = NUM_DEV + 1;
  localparam int SEL_GPIO    = NUM_DEV;
  localparam int GPIO_SPAN   = 2;
  localparam int GPIO_EN_BIT = 7;
  localparam int IRQ_MAX     = 15;
  localparam int WIN_FLOOR   = 'h0100;

  localparam int DEV_FDD   = 0;
  localparam int DEV_PAR   = 1;
  localparam int DEV_SERA  = 2;
  localparam int DEV_SERB  = 3;
  localparam int DEV_AUXIO = 4;
  localparam int DEV_BUS2W = 5;

  function automatic int dev_span(input int idx);
    case (idx)
      DEV_PAR, DEV_BUS2W: return 4;
      DEV_AUXIO:          return 1;
      default:            return 8;
    endcase
  endfunction

  function automatic int dev_win_hi(input int idx);
    case (idx)
      DEV_PAR, DEV_BUS2W: return 'h0FFC;
      DEV_AUXIO:          return 'h0FFF;
      default:            return 'h0FF8;
    endcase
  endfunction

  function automatic int dev_gbit(input int idx);
    case (idx)
      DEV_FDD:   return 0;
      DEV_PAR:   return 3;
      DEV_SERA:  return 4;
      DEV_SERB:  return 5;
      DEV_BUS2W: return 6;
      default:   return 0;
    endcase
  endfunction

  function automatic bit dev_needs_global(input int idx);
    return idx != DEV_AUXIO;
  endfunction

  function automatic bit dev_clamps_irq(input int idx);
    return idx == DEV_PAR;
  endfunction

  function automatic logic [15:0] gpio_base(input logic [1:0] pick);
    case (pick)
      2'd0:    return 16'h00E0;
      2'd1:    return 16'h00E2;
      2'd2:    return 16'h00E4;
      default: return 16'h00EA;
    endcase
  endfunction
endpackage

// File: rtl/sio_dev_window.sv
module sio_dev_window #(
  parameter int REG_W       = 8,
  parameter int SPAN        = 8,
  parameter int WIN_LO      = 'h0100,
  parameter int WIN_HI      = 'h0FF8,
  parameter bit NEED_GLOBAL = 1'b1,
  localparam int ADDR_W     = 2 * REG_W
) (
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [REG_W-1:0]  base_hi,
  input  logic [REG_W-1:0]  base_lo,
  input  logic [REG_W-1:0]  activate,
  input  logic              global_en,
  output logic              hit
);
  logic [ADDR_W-1:0] base;
  logic [ADDR_W:0]   limit;
  logic              gate_ok;
  logic              legal;
  logic              in_span;

  assign base  = {base_hi, base_lo};
  assign limit = {1'b0, base} + (ADDR_W+1)'(SPAN);

  generate
    if (NEED_GLOBAL) begin : g_gated
      assign gate_ok = global_en;
    end else begin : g_free
      logic unused_global;
      assign unused_global = global_en;
      assign gate_ok = 1'b1;
    end
  endgenerate

  assign legal   = (base >= ADDR_W'(WIN_LO)) && (base <= ADDR_W'(WIN_HI));
  assign in_span = (host_addr >= base) && ({1'b0, host_addr} < limit);
  assign hit     = gate_ok && (|activate) && legal && in_span;
endmodule

// File: rtl/sio_gpio_window.sv
module sio_gpio_window
  import sio_dec_pkg::*;
#(
  parameter int REG_W   = 8,
  localparam int ADDR_W = 2 * REG_W
) (
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [REG_W-1:0]  ctl,
  output logic              hit
);
  logic [ADDR_W-1:0] base;
  logic [ADDR_W:0]   limit;
  logic              unused_ctl;

  assign unused_ctl = ^ctl[GPIO_EN_BIT-1:2];
  assign base  = ADDR_W'(gpio_base(ctl[1:0]));
  assign limit = {1'b0, base} + (ADDR_W+1)'(GPIO_SPAN);
  assign hit   = ctl[GPIO_EN_BIT] && (host_addr >= base) && ({1'b0, host_addr} < limit);
endmodule

// File: rtl/sio_irq_filter.sv
module sio_irq_filter #(
  parameter int REG_W = 8,
  parameter bit CLAMP = 1'b0,
  parameter int LIMIT = 15
) (
  input  logic [REG_W-1:0] irq_in,
  output logic [REG_W-1:0] irq_out
);
  generate
    if (CLAMP) begin : g_clamp
      assign irq_out = (irq_in > REG_W'(LIMIT)) ? '1 : irq_in;
    end else begin : g_pass
      assign irq_out = irq_in;
    end
  endgenerate
endmodule

// File: rtl/sio_sel_prio.sv
module sio_sel_prio #(
  parameter int N = 7
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  logic [N:0] taken;
  assign taken[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]   = req[i] && !taken[i];
    assign taken[i+1] = taken[i] || req[i];
  end
endmodule

// File: rtl/sio_addr_decoder.sv
module sio_addr_decoder
  import sio_dec_pkg::*;
#(
  parameter int REG_W   = 8,
  localparam int ADDR_W = 2 * REG_W
) (
  input  logic [ADDR_W-1:0]              host_addr,
  input  logic [REG_W-1:0]               glob_en_reg,
  input  logic [REG_W-1:0]               gpio_ctl_reg,
  input  logic [NUM_DEV-1:0][REG_W-1:0]  activate,
  input  logic [NUM_DEV-1:0][REG_W-1:0]  base_hi,
  input  logic [NUM_DEV-1:0][REG_W-1:0]  base_lo,
  input  logic [NUM_DEV-1:0][REG_W-1:0]  irq_reg,
  output logic [NUM_SEL-1:0]             dev_sel,
  output logic [NUM_DEV-1:0][REG_W-1:0]  dev_irq
);
  logic [NUM_SEL-1:0] raw_hit;
  logic [REG_W-1:0]   glob_used;
  logic               unused_glob;

  always_comb begin
    glob_used = '0;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (dev_needs_global(i)) glob_used[dev_gbit(i)] = 1'b1;
    end
  end
  assign unused_glob = ^(glob_en_reg & ~glob_used);

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
    sio_dev_window #(
      .REG_W       (REG_W),
      .SPAN        (dev_span(i)),
      .WIN_LO      (WIN_FLOOR),
      .WIN_HI      (dev_win_hi(i)),
      .NEED_GLOBAL (dev_needs_global(i))
    ) win_i (
      .host_addr (host_addr),
      .base_hi   (base_hi[i]),
      .base_lo   (base_lo[i]),
      .activate  (activate[i]),
      .global_en (glob_en_reg[dev_gbit(i)]),
      .hit       (raw_hit[i])
    );

    sio_irq_filter #(
      .REG_W (REG_W),
      .CLAMP (dev_clamps_irq(i)),
      .LIMIT (IRQ_MAX)
    ) irq_i (
      .irq_in  (irq_reg[i]),
      .irq_out (dev_irq[i])
    );
  end

  sio_gpio_window #(.REG_W(REG_W)) gpio_i (
    .host_addr (host_addr),
    .ctl       (gpio_ctl_reg),
    .hit       (raw_hit[SEL_GPIO])
  );

  sio_sel_prio #(.N(NUM_SEL)) prio_i (
    .req   (raw_hit),
    .grant (dev_sel)
  );
endmodule

// File: rtl/sio_addr_decoder_chk.sv
module sio_addr_decoder_chk
  import sio_dec_pkg::*;
#(
  parameter int REG_W   = 8,
  localparam int ADDR_W = 2 * REG_W
) (
  input logic [ADDR_W-1:0]              host_addr,
  input logic [REG_W-1:0]               glob_en_reg,
  input logic [REG_W-1:0]               gpio_ctl_reg,
  input logic [NUM_DEV-1:0][REG_W-1:0]  activate,
  input logic [NUM_DEV-1:0][REG_W-1:0]  base_hi,
  input logic [NUM_DEV-1:0][REG_W-1:0]  base_lo,
  input logic [NUM_DEV-1:0][REG_W-1:0]  irq_reg,
  input logic [NUM_SEL-1:0]             dev_sel,
  input logic [NUM_DEV-1:0][REG_W-1:0]  dev_irq
);
  always_comb begin
    // R8: never two selects at once
    assert_sel_onehot_R8: assert ($onehot0(dev_sel))
      else $error("dev_sel not one-hot: %b", dev_sel);

    for (int i = 0; i < NUM_DEV; i++) begin
      if (dev_sel[i]) begin
        // R5: a select needs a nonzero activation byte
        assert_act_gate_R5: assert (activate[i] != '0)
          else $error("function %0d selected while inactive", i);
        // R4: gated functions need their global bit
        assert_glob_gate_R4: assert (!dev_needs_global(i) || glob_en_reg[dev_gbit(i)])
          else $error("function %0d selected with global bit clear", i);
        // R3: base in legal range
        assert_window_R3: assert (({base_hi[i], base_lo[i]} >= ADDR_W'(WIN_FLOOR)) &&
                                  ({base_hi[i], base_lo[i]} <= ADDR_W'(dev_win_hi(i))))
          else $error("function %0d selected with illegal base", i);
        // R1: address within the function's span
        assert_span_R1: assert ((host_addr >= {base_hi[i], base_lo[i]}) &&
                                ((host_addr - {base_hi[i], base_lo[i]}) < ADDR_W'(dev_span(i))))
          else $error("function %0d selected outside its span", i);
      end
    end

    // R6: GPIO select requires its enable bit
    if (dev_sel[SEL_GPIO]) begin
      assert_gpio_en_R6: assert (gpio_ctl_reg[GPIO_EN_BIT])
        else $error("GPIO selected while disabled");
    end

    // R7: parallel interrupt number limited
    if (irq_reg[DEV_PAR] > REG_W'(IRQ_MAX)) begin
      assert_irq_clamp_R7: assert (dev_irq[DEV_PAR] == '1)
        else $error("parallel irq not limited: %h", dev_irq[DEV_PAR]);
    end
  end
endmodule

bind sio_addr_decoder sio_addr_decoder_chk #(.REG_W(REG_W)) chk_i (.*);

// File: tb/sio_addr_decoder_tb_top.sv
module sio_addr_decoder_tb_top;
  localparam int NDEV = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [15:0]           haddr;
  logic [7:0]            glob;
  logic [7:0]            gctl;
  logic [NDEV-1:0][7:0]  act;
  logic [NDEV-1:0][7:0]  bhi;
  logic [NDEV-1:0][7:0]  blo;
  logic [NDEV-1:0][7:0]  irq;
  logic [6:0]            dev_sel;
  logic [NDEV-1:0][7:0]  dev_irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  sio_addr_decoder dut_i (
    .host_addr    (haddr),
    .glob_en_reg  (glob),
    .gpio_ctl_reg (gctl),
    .activate     (act),
    .base_hi      (bhi),
    .base_lo      (blo),
    .irq_reg      (irq),
    .dev_sel      (dev_sel),
    .dev_irq      (dev_irq)
  );

  // Arithmetic reference built from the requirement text
  function automatic logic [6:0] model(input int a);
    int span [NDEV] = '{8, 4, 8, 8, 1, 4};
    int whi  [NDEV] = '{'h0FF8, 'h0FFC, 'h0FF8, 'h0FF8, 'h0FFF, 'h0FFC};
    int gbit [NDEV] = '{0, 3, 4, 5, -1, 6};
    int gb   [4]    = '{'hE0, 'hE2, 'hE4, 'hEA};
    logic [6:0] hits = '0;
    for (int i = 0; i < NDEV; i++) begin
      int base = int'(bhi[i]) * 256 + int'(blo[i]);
      hits[i] = (act[i] != 0) && (gbit[i] < 0 || glob[gbit[i]]) &&
                base >= 'h0100 && base <= whi[i] && a >= base && a < base + span[i];
    end
    hits[6] = gctl[7] && a >= gb[gctl[1:0]] && a < gb[gctl[1:0]] + 2;
    for (int i = 0; i < 7; i++) if (hits[i]) return 7'(1 << i);
    return '0;
  endfunction

  task automatic chk_sel(input int a, input string tag);
    logic [6:0] exp;
    @(negedge clk);
    haddr = 16'(a);
    #1;
    exp = model(a);
    checks++;
    if (dev_sel !== exp) begin
      fails++;
      $display("FAIL %s addr=%h actual=%b expected=%b", tag, 16'(a), dev_sel, exp);
    end
  endtask

  task automatic chk_lit(input int a, input logic [6:0] exp, input string tag);
    @(negedge clk);
    haddr = 16'(a);
    #1;
    checks++;
    if (dev_sel !== exp) begin
      fails++;
      $display("FAIL %s addr=%h actual=%b expected=%b", tag, 16'(a), dev_sel, exp);
    end
  endtask

  task automatic sweep(input int lo, input int hi, input string tag);
    for (int a = lo; a <= hi; a++) chk_sel(a, tag);
  endtask

  task automatic set_dev(input int i, input logic [7:0] a, input logic [15:0] b);
    act[i] = a;
    bhi[i] = b[15:8];
    blo[i] = b[7:0];
  endtask

  task automatic power_on_defaults();
    glob = 8'h39;
    gctl = 8'h03;
    set_dev(0, 8'h01, 16'h03F0);
    set_dev(1, 8'h01, 16'h0378);
    set_dev(2, 8'h01, 16'h03F8);
    set_dev(3, 8'h01, 16'h02F8);
    set_dev(4, 8'h00, 16'h0000);
    set_dev(5, 8'h00, 16'h0000);
    irq = '0;
  endtask

  // Watchdog: expiry counts as a failed check
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int bounds [8] = '{'h00FF, 'h0100, 'h0FF8, 'h0FF9, 'h0FFC, 'h0FFD, 'h0FFF, 'h1000};
    haddr = '0; glob = '0; gctl = '0; act = '0; bhi = '0; blo = '0; irq = '0;
    repeat (3) @(posedge clk);
    // R5: all activation bytes zero during reset, nothing selected
    chk_lit(0, 7'b0, "R5 reset");
    rst = 1'b0;

    // R1 R2: power-on style layout, full legal range
    power_on_defaults();
    sweep(0, 'h1007, "R1");
    chk_lit('h03F7, 7'b0000001, "R2 floppy last port");
    chk_lit('h03F8, 7'b0000100, "R2 serial-A first port");
    chk_lit('h037B, 7'b0000010, "R2 parallel last port");
    chk_lit('h037C, 7'b0000000, "R2 parallel past span");
    chk_lit('h02FF, 7'b0001000, "R2 serial-B last port");

    // R6: everything on, auxiliary and two-wire bus placed, GPIO on
    glob = 8'hFF;
    set_dev(4, 8'h40, 16'h0100);
    set_dev(5, 8'h80, 16'h0200);
    gctl = 8'h83;
    sweep(0, 'h0FFF, "R6");
    chk_lit('h0100, 7'b0010000, "R2 auxiliary single port");
    chk_lit('h0101, 7'b0000000, "R2 auxiliary past span");
    chk_lit('h00EB, 7'b1000000, "R6 GPIO upper port");

    // R6: every base choice, enabled and disabled
    for (int f = 0; f < 4; f++) begin
      gctl = 8'h80 | 8'(f);
      sweep('hD8, 'hF0, "R6 enabled");
      gctl = 8'h7C | 8'(f);
      sweep('hD8, 'hF0, "R6 disabled");
    end

    // R8: stacked overlapping windows
    gctl = 8'h80;
    set_dev(0, 8'h01, 16'h0300);
    set_dev(1, 8'h01, 16'h0300);
    set_dev(2, 8'h01, 16'h0302);
    set_dev(3, 8'h01, 16'h0300);
    set_dev(4, 8'h01, 16'h0300);
    set_dev(5, 8'h01, 16'h0304);
    sweep('h02F0, 'h0320, "R8");
    chk_lit('h0300, 7'b0000001, "R8 floppy wins");
    glob = 8'hFE;
    chk_lit('h0300, 7'b0000010, "R8 parallel next");
    glob = 8'hF6;
    sweep('h02F0, 'h0320, "R8 reduced");

    // R3: bases on and just past every range edge
    glob = 8'hFF;
    gctl = 8'h00;
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < NDEV; i++) set_dev(i, 8'h01, 16'(bounds[k]));
      sweep(bounds[k] - 2, bounds[k] + 9, "R3");
      for (int i = 0; i < NDEV; i++) set_dev(i, (i == k % NDEV) ? 8'h01 : 8'h00, 16'(bounds[k]));
      sweep(bounds[k] - 2, bounds[k] + 9, "R3 single");
    end

    // R4: global byte patterns, including only the unused bits
    power_on_defaults();
    set_dev(4, 8'h01, 16'h0800);
    set_dev(5, 8'h01, 16'h0900);
    glob = 8'h86;
    sweep('h02F0, 'h0910, "R4 unused bits");
    chk_lit('h0800, 7'b0010000, "R4 auxiliary ignores global");
    glob = 8'h40;
    chk_lit('h0901, 7'b0100000, "R4 bus bit 6");
    for (int b = 0; b < 8; b++) begin
      glob = 8'(1 << b);
      sweep('h02F0, 'h0400, "R4 single bit");
    end

    // R5: any nonzero activation value counts
    glob = 8'hFF;
    for (int i = 0; i < NDEV; i++) act[i] = 8'(1 << (i + 2));
    sweep('h02F0, 'h0400, "R5 nonzero");
    act[0] = 8'h00;
    chk_lit('h03F0, 7'b0000000, "R5 floppy inactive");

    // R9: selects follow each address change within the same cycle
    @(negedge clk);
    haddr = 16'h03F8;
    #1;
    checks++;
    if (dev_sel !== 7'b0000100) begin
      fails++;
      $display("FAIL R9 actual=%b expected=%b", dev_sel, 7'b0000100);
    end
    haddr = 16'h02F8;
    #1;
    checks++;
    if (dev_sel !== 7'b0001000) begin
      fails++;
      $display("FAIL R9 actual=%b expected=%b", dev_sel, 7'b0001000);
    end

    // R7: every interrupt value on every function
    for (int i = 0; i < NDEV; i++) begin
      for (int v = 0; v < 256; v++) begin
        logic [7:0] e;
        @(negedge clk);
        irq[i] = 8'(v);
        #1;
        e = (i == 1 && v > 15) ? 8'hFF : 8'(v);
        checks++;
        if (dev_irq[i] !== e) begin
          fails++;
          $display("FAIL R7 dev=%0d actual=%h expected=%h", i, dev_irq[i], e);
        end
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule